// File: doc/BRIEF.md
# CAN Error Flag Aggregator

This block gathers the error events reported by a CAN protocol engine into two sticky registers and condenses them into one interrupt line. The first register holds one flag per error kind, and each flag has its own enable. The second register records the causes of bus errors. It can either add up causes over many errors or hold only the causes of the latest one. A two-level summary combines the enabled error flags into one error bit. That bit sits in an interrupt status vector next to the mailbox receive and transmit completion levels, and the line to the processor is the OR of every enabled status bit.

Software reads all registers directly from the output ports. It writes through one narrow write port that has a two-bit target select. Writes to the error-kind register and to the cause bits of the cause register can only clear flags: a 0 clears the flag in that position and a 1 leaves it as it is. Software can therefore clear exactly one flag by writing the inverse of that flag's bit. The counting of error counters and the protocol engine itself lie outside this block.

Top module: `can_err_flags`

## Requirements
- R1: After reset, the error-kind register, the cause register, both enable registers, the status vector and the interrupt line are all zero.
- R2: A pulse on an event input sets the matching error-kind flag, and the flag is visible the cycle after the pulse. The error-kind positions are: bit 7 bus lock, bit 6 overload frame sent, bit 5 receive overrun, bit 4 bus-off recovery, bit 3 bus-off entry, bit 2 error passive, bit 1 error warning, bit 0 bus error. A flag never sets unless its event was pulsed.
- R3: A write with select 0 clears every error-kind flag whose data bit is 0 and keeps every flag whose data bit is 1. With no write and no event, the register holds its value.
- R4: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: The cause register positions are: bit 6 ACK delimiter error, bit 5 dominant bit error, bit 4 recessive bit error, bit 3 CRC error, bit 2 ACK error, bit 1 form error, bit 0 stuff error. Bit 7 is the mode bit. When bit 7 is 1, each bus-error event (event bit 0) ORs its causes into bits 6:0.
- R6: When bit 7 is 0, each bus-error event replaces bits 6:0 with only that event's causes.
- R7: Cause inputs have no effect in a cycle without a bus-error event.
- R8: A write with select 1 clears the cause bits 6:0 whose data bit is 0 and loads bit 7 directly from the data. The mode bit changes only through this write. A cause that arrives in the same cycle is still recorded.
- R9: In the status vector, bit 5 is 1 exactly when some error-kind flag and its enable bit are both 1. Bits 2, 1 and 0 follow the mailbox-0 receive, other-mailbox receive and transmit-done inputs. Bits 7, 6, 4 and 3 are 0.
- R10: The interrupt line is 1 exactly when some status bit and its interrupt enable bit are both 1.
- R11: A write with select 2 loads the error-kind enable register, and a write with select 3 loads the interrupt enable register. Both loads are plain and visible the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | 8 | Error event pulses, in the error-kind bit positions |
| cause_i | input | 7 | Bus-error causes, sampled with event bit 0 |
| mbx_i | input | 3 | Mailbox completion levels: bit 2 mailbox 0 receive, bit 1 other receive, bit 0 transmit |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 error kinds, 1 causes, 2 kind enable, 3 interrupt enable |
| wr_data_i | input | 8 | Write data |
| fac_o | output | 8 | Error-kind flags |
| code_o | output | 8 | Mode bit and bus-error causes |
| fen_o | output | 8 | Error-kind enable register |
| ien_o | output | 8 | Interrupt enable register |
| stat_o | output | 8 | Interrupt status vector |
| irq_o | output | 1 | Interrupt request |

## Verification
Every register is visible at the ports, so a wrong flag, cause bit or enable bit shows up in the cycle after the edge that corrupted it. The status vector and the interrupt line are combinational views of that state, so a wrong summary shows up in the same sample as the state behind it. The bench compares every output on every cycle against a model built from the requirements. A lost set, a clear that removes too much, or a merge or replace done in the wrong mode therefore fails on the first affected cycle. It is not left to surface later through the interrupt line.

// File: rtl/can_ef_pkg.sv
package can_ef_pkg;
  localparam int unsigned KIND_W  = 8;
  localparam int unsigned CAUSE_W = 7;
  localparam int unsigned CODE_W  = CAUSE_W + 1;
  localparam int unsigned STAT_W  = 8;
  localparam int unsigned MBX_W   = 3;
  localparam int unsigned SUM_POS = 5;
  localparam int unsigned BERR_POS = 0;

  typedef enum logic [1:0] {
    SEL_KIND  = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_KEN   = 2'd2,
    SEL_IEN   = 2'd3
  } wsel_e;
endpackage

// File: rtl/cef_w0c_reg.sv
module cef_w0c_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic [W-1:0] kept;
  logic         upd;

  always_comb begin
    kept  = clr_we_i ? (q_r & clr_data_i) : q_r;
    q_nxt = ld_i ? ld_val_i : (kept | set_i);
    upd   = ld_i | clr_we_i | (|set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/cef_code_store.sv
module cef_code_store #(
  parameter int unsigned NC = 7,
  localparam int unsigned CW = NC + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          berr_i,
  input  logic [NC-1:0] cause_i,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] code_o
);
  logic          mode_r;
  logic          mode_nxt;
  logic [NC-1:0] cause_q;
  logic [NC-1:0] set_v;
  logic          replace;

  always_comb begin
    mode_nxt = wdata_i[NC];
    replace  = berr_i & ~mode_r;
    set_v    = (berr_i & mode_r) ? cause_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_r <= 1'b0;
    else if (wr_i) mode_r <= mode_nxt;
  end

  cef_w0c_reg #(.W(NC)) u_cause (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (set_v),
    .clr_we_i   (wr_i),
    .clr_data_i (wdata_i[NC-1:0]),
    .ld_i       (replace),
    .ld_val_i   (cause_i),
    .q_o        (cause_q)
  );

  assign code_o = {mode_r, cause_q};
endmodule

// File: rtl/cef_irq_sum.sv
module cef_irq_sum
  import can_ef_pkg::*;
(
  input  logic [KIND_W-1:0] kind_i,
  input  logic [KIND_W-1:0] ken_i,
  input  logic [MBX_W-1:0]  mbx_i,
  input  logic [STAT_W-1:0] ien_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  logic err_any;

  always_comb begin
    err_any = |(kind_i & ken_i);
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_stat
    if (b == SUM_POS) begin : g_sum
      assign stat_o[b] = err_any;
    end else if (b < MBX_W) begin : g_mbx
      assign stat_o[b] = mbx_i[b];
    end else begin : g_pad
      assign stat_o[b] = 1'b0;
    end
  end

  assign irq_o = |(stat_o & ien_i);
endmodule

// File: rtl/can_err_flags.sv
module can_err_flags
  import can_ef_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [KIND_W-1:0]  ev_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [MBX_W-1:0]   mbx_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [7:0]         wr_data_i,
  output logic [KIND_W-1:0]  fac_o,
  output logic [CODE_W-1:0]  code_o,
  output logic [KIND_W-1:0]  fen_o,
  output logic [STAT_W-1:0]  ien_o,
  output logic [STAT_W-1:0]  stat_o,
  output logic               irq_o
);
  wsel_e sel;
  logic  wr_kind, wr_cause, wr_ken, wr_ien;
  logic [KIND_W-1:0] ken_r, ken_nxt;
  logic [STAT_W-1:0] ien_r, ien_nxt;

  always_comb begin
    sel      = wsel_e'(wr_sel_i);
    wr_kind  = wr_en_i && (sel == SEL_KIND);
    wr_cause = wr_en_i && (sel == SEL_CAUSE);
    wr_ken   = wr_en_i && (sel == SEL_KEN);
    wr_ien   = wr_en_i && (sel == SEL_IEN);
    ken_nxt  = wr_data_i[KIND_W-1:0];
    ien_nxt  = wr_data_i[STAT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ken_r <= '0;
      ien_r <= '0;
    end else begin
      if (wr_ken) ken_r <= ken_nxt;
      if (wr_ien) ien_r <= ien_nxt;
    end
  end

  cef_w0c_reg #(.W(KIND_W)) u_kind (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (ev_i),
    .clr_we_i   (wr_kind),
    .clr_data_i (wr_data_i[KIND_W-1:0]),
    .ld_i       (1'b0),
    .ld_val_i   ('0),
    .q_o        (fac_o)
  );

  cef_code_store #(.NC(CAUSE_W)) u_code (
    .clk     (clk),
    .rst_n   (rst_n),
    .berr_i  (ev_i[BERR_POS]),
    .cause_i (cause_i),
    .wr_i    (wr_cause),
    .wdata_i (wr_data_i[CODE_W-1:0]),
    .code_o  (code_o)
  );

  cef_irq_sum u_sum (
    .kind_i (fac_o),
    .ken_i  (ken_r),
    .mbx_i  (mbx_i),
    .ien_i  (ien_r),
    .stat_o (stat_o),
    .irq_o  (irq_o)
  );

  assign fen_o = ken_r;
  assign ien_o = ien_r;
endmodule

// File: rtl/cef_chk.sv
module cef_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ev_i,
  input logic       wr_en_i,
  input logic [1:0] wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] fac_o,
  input logic [7:0] code_o,
  input logic [7:0] ien_o,
  input logic [7:0] stat_o,
  input logic       irq_o
);
  // R2
  fac_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_i) |=> ((fac_o & $past(ev_i)) == $past(ev_i)));

  // R2
  fac_norise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fac_o & ~$past(fac_o) & ~$past(ev_i)) == 8'h00));

  // R3
  fac_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en_i && wr_sel_i == 2'd0) && ev_i == 8'h00) |=> $stable(fac_o));

  // R3
  fac_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 2'd0 && ev_i == 8'h00) |=>
      (fac_o == ($past(fac_o) & $past(wr_data_i))));

  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_i[0] && !(wr_en_i && wr_sel_i == 2'd1)) |=> $stable(code_o));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && wr_sel_i == 2'd1) |=> $stable(code_o[7]));

  // R9
  stat_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_o & 8'hD8) == 8'h00));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_o & ien_o) == 8'h00) |-> !irq_o);
endmodule

bind can_err_flags cef_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_i      (ev_i),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .fac_o     (fac_o),
  .code_o    (code_o),
  .ien_o     (ien_o),
  .stat_o    (stat_o),
  .irq_o     (irq_o)
);

// File: tb/tb_can_err_flags.sv
`timescale 1ns/1ps
module tb_can_err_flags;
  logic       clk;
  logic       rst_n;
  logic [7:0] ev_i;
  logic [6:0] cause_i;
  logic [2:0] mbx_i;
  logic       wr_en_i;
  logic [1:0] wr_sel_i;
  logic [7:0] wr_data_i;
  logic [7:0] fac_o, code_o, fen_o, ien_o, stat_o;
  logic       irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] m_fac, m_code, m_fen, m_ien;

  can_err_flags dut (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .cause_i(cause_i), .mbx_i(mbx_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .fac_o(fac_o), .code_o(code_o), .fen_o(fen_o), .ien_o(ien_o),
    .stat_o(stat_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] nxt_fac(logic [7:0] f, logic [7:0] ev,
                                         logic we, logic [1:0] s, logic [7:0] d);
    logic [7:0] k;
    k = (we && s == 2'd0) ? (f & d) : f;
    return k | ev;
  endfunction

  function automatic logic [7:0] nxt_code(logic [7:0] c, logic berr, logic [6:0] cs,
                                          logic we, logic [1:0] s, logic [7:0] d);
    logic [6:0] k;
    logic       md;
    k  = (we && s == 2'd1) ? (c[6:0] & d[6:0]) : c[6:0];
    md = (we && s == 2'd1) ? d[7] : c[7];
    if (berr) k = c[7] ? (k | cs) : cs;
    return {md, k};
  endfunction

  function automatic logic [7:0] exp_stat(logic [7:0] f, logic [7:0] e, logic [2:0] m);
    return {2'b00, |(f & e), 2'b00, m};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [7:0] st;
    st = exp_stat(m_fac, m_fen, mbx_i);
    chk("R2 kind flags", fac_o, m_fac);
    chk("R5 cause register", code_o, m_code);
    chk("R11 kind enable", fen_o, m_fen);
    chk("R11 irq enable", ien_o, m_ien);
    chk("R9 status", stat_o, st);
    chk("R10 irq", {7'd0, irq_o}, {7'd0, |(st & m_ien)});
  endtask

  // called at a negedge: apply inputs, advance one edge, compare at next negedge
  task automatic step(logic [7:0] ev, logic [6:0] cs, logic [2:0] mb,
                      logic we, logic [1:0] s, logic [7:0] d);
    ev_i = ev; cause_i = cs; mbx_i = mb; wr_en_i = we; wr_sel_i = s; wr_data_i = d;
    @(posedge clk);
    m_fac  = nxt_fac(m_fac, ev, we, s, d);
    m_code = nxt_code(m_code, ev[0], cs, we, s, d);
    if (we && s == 2'd2) m_fen = d;
    if (we && s == 2'd3) m_ien = d;
    @(negedge clk);
    check_all();
  endtask

  task automatic idle();
    step(8'h00, 7'h00, mbx_i, 1'b0, 2'd0, 8'h00);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    ev_i = '0; cause_i = '0; mbx_i = '0; wr_en_i = 0; wr_sel_i = '0; wr_data_i = '0;
    m_fac = '0; m_code = '0; m_fen = '0; m_ien = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 kind", fac_o, 8'h00);
    chk("R1 cause", code_o, 8'h00);
    chk("R1 enables", fen_o | ien_o, 8'h00);
    chk("R1 status", stat_o, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);

    // R2 / R3
    step(8'hA0, 7'h00, 3'b000, 1'b0, 2'd0, 8'h00);
    chk("R2 bus lock and overrun", fac_o, 8'hA0);
    step(8'h5F, 7'h00, 3'b000, 1'b0, 2'd0, 8'h00);
    chk("R2 all kinds", fac_o, 8'hFF);
    step(8'h00, 7'h00, 3'b000, 1'b1, 2'd0, 8'hFB);
    chk("R3 single clear", fac_o, 8'hFB);
    step(8'h00, 7'h00, 3'b000, 1'b1, 2'd0, 8'h0F);
    chk("R3 nibble clear", fac_o, 8'h0B);
    // R4 event wins
    step(8'h02, 7'h00, 3'b000, 1'b1, 2'd0, 8'h00);
    chk("R4 event beats clear", fac_o, 8'h02);

    // R6 latest mode
    step(8'h01, 7'h05, 3'b000, 1'b0, 2'd0, 8'h00);
    chk("R6 first error", code_o, 8'h05);
    step(8'h01, 7'h08, 3'b000, 1'b0, 2'd0, 8'h00);
    chk("R6 replaced", code_o, 8'h08);
    // R8 mode write
    step(8'h00, 7'h00, 3'b000, 1'b1, 2'd1, 8'h80);
    chk("R8 mode set clears causes", code_o, 8'h80);
    // R5 accumulate
    step(8'h01, 7'h01, 3'b000, 1'b0, 2'd0, 8'h00);
    chk("R5 accumulate 1", code_o, 8'h81);
    step(8'h01, 7'h10, 3'b000, 1'b0, 2'd0, 8'h00);
    chk("R5 accumulate 2", code_o, 8'h91);
    // R7 cause without bus error
    step(8'h04, 7'h7F, 3'b000, 1'b0, 2'd0, 8'h00);
    chk("R7 cause ignored", code_o, 8'h91);
    // R8 clears
    step(8'h00, 7'h00, 3'b000, 1'b1, 2'd1, 8'hFE);
    chk("R8 clear stuff bit", code_o, 8'h90);
    step(8'h00, 7'h00, 3'b000, 1'b1, 2'd1, 8'h7F);
    chk("R8 mode cleared", code_o, 8'h10);
    // R8 cause same cycle as clear in accumulate mode
    step(8'h00, 7'h00, 3'b000, 1'b1, 2'd1, 8'h80);
    step(8'h01, 7'h02, 3'b000, 1'b1, 2'd1, 8'h80);
    chk("R8 cause beats clear", code_o, 8'h82);

    // R9 / R10 / R11
    step(8'h00, 7'h00, 3'b000, 1'b1, 2'd1, 8'h00);
    step(8'h00, 7'h00, 3'b000, 1'b1, 2'd0, 8'h00);
    step(8'h00, 7'h00, 3'b000, 1'b1, 2'd2, 8'h08);
    chk("R11 kind enable", fen_o, 8'h08);
    step(8'h00, 7'h00, 3'b000, 1'b1, 2'd3, 8'h20);
    chk("R11 irq enable", ien_o, 8'h20);
    chk("R10 quiet", {7'd0, irq_o}, 8'h00);
    step(8'h04, 7'h00, 3'b000, 1'b0, 2'd0, 8'h00);
    chk("R9 disabled kind no summary", stat_o, 8'h00);
    step(8'h08, 7'h00, 3'b000, 1'b0, 2'd0, 8'h00);
    chk("R9 summary", stat_o, 8'h20);
    chk("R10 error irq", {7'd0, irq_o}, 8'h01);
    step(8'h00, 7'h00, 3'b101, 1'b1, 2'd3, 8'h01);
    chk("R9 mailbox levels", stat_o, 8'h25);
    chk("R10 transmit irq", {7'd0, irq_o}, 8'h01);
    step(8'h00, 7'h00, 3'b110, 1'b0, 2'd0, 8'h00);
    chk("R10 masked", {7'd0, irq_o}, 8'h00);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] ev;
      logic       we;
      ev = 8'($urandom & $urandom & $urandom);
      we = ($urandom % 4) == 0;
      step(ev, 7'($urandom), 3'($urandom), we, 2'($urandom), 8'($urandom));
    end
    idle();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule